// File: doc/BRIEF.md
# Three-Stage In-Order Pipelined Core

This block is a small in-order processor core with three steps: a fetch/decode latch, an operand latch and a retire step. Each cycle it presents its program counter to an external read-only instruction store and takes the returned 16-bit word into the first latch. The first latch holds the decoded fields. When the instruction moves on, its two source registers are read into the second latch. In the following cycle the ALU result is written to the destination register and shown on the retire port.

Data hazards are handled only by interlocking. There is no forwarding. The pipeline control has two named states, decided every cycle:

- **RUN**: the first latch advances, the PC increments and a new word is fetched.
- **HOLD**: entered when the first-latch instruction reads a register that the valid second-latch instruction will write. In this state the first latch and the PC stay as they are, and a bubble enters the second latch.

The transition RUN→HOLD happens on a detected hazard. HOLD→RUN always follows on the next cycle, because the bubble removes the hazard.

Top module: `pipe3_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and both `retire_valid` and `stall` are 0. The first retirement appears after the second rising edge following reset release, so `retire_valid` is 0 after the first edge.
- R2: The instruction word is decoded with the opcode in bits [15:12], the destination in [11:8], source A in [7:4] and source B in [3:0].
- R3: Opcodes 0..5 select A+B, A−B, A&B, A|B, A^B and pass-through of A, all modulo 2^16.
- R4: In every RUN cycle the PC, shown on `imem_addr`, increments by one.
- R5: `stall` is 1 exactly when the valid first-latch instruction names, as A or B, the destination of the valid second-latch instruction. It therefore only occurs while `retire_valid` is 1, and never lasts two consecutive cycles.
- R6: During a HOLD cycle the PC does not change. In the next cycle `retire_valid` is 0 (bubble).
- R7: Instructions retire one per non-bubble cycle, in fetch order.
- R8: The register file changes only at retirement. After reset, register i holds the value i.
- R9: Opcodes 6..15 retire a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | ADDR_W | Program counter, address of the next fetch |
| imem_data | input | 16 | Instruction word read at `imem_addr` |
| stall | output | 1 | High in a HOLD cycle |
| retire_valid | output | 1 | An instruction retires this cycle |
| retire_dest | output | 4 | Destination register of the retiring instruction |
| retire_value | output | DATA_W | Result written to the destination |

## Verification
A hazard stall and the retirement of the producing instruction always fall in the same cycle. In that cycle the register write must land before the held consumer reads its operands on the following edge. The test program chains dependent instructions through source A, through source B and through register 0, so this overlap is provoked seven times. It is judged by the retired values, which are only correct if each consumer saw the new value, by a bubble in the cycle after each stall, and by a frozen PC.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
    parameter int OPC_W   = 4;
    parameter int REG_W   = 4;
    parameter int NREG    = 1 << REG_W;
    parameter int INSTR_W = OPC_W + 3 * REG_W;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_PASS = 4'd5
    } op_e;

    typedef enum logic {
        CTL_RUN  = 1'b0,
        CTL_HOLD = 1'b1
    } ctl_e;

    typedef struct packed {
        logic             vld;
        logic [OPC_W-1:0] op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
    } fetch_lat_t;
endpackage

// File: rtl/pipe3_alu.sv
module pipe3_alu
    import pipe3_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_PASS: y = a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pipe3_regfile.sv
module pipe3_regfile
    import pipe3_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  rd_a_addr,
    input  logic [REG_W-1:0]  rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= DATA_W'(i);
            end
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    assign rd_a_data = regs[rd_a_addr];
    assign rd_b_data = regs[rd_b_addr];
endmodule

// File: rtl/pipe3_hazard.sv
module pipe3_hazard
    import pipe3_pkg::*;
(
    input  logic             fl_vld,
    input  logic [REG_W-1:0] fl_ra,
    input  logic [REG_W-1:0] fl_rb,
    input  logic             op_vld,
    input  logic [REG_W-1:0] op_rd,
    output ctl_e             mode
);
    logic clash;

    always_comb begin
        clash = fl_vld && op_vld && ((fl_ra == op_rd) || (fl_rb == op_rd));
        mode  = clash ? CTL_HOLD : CTL_RUN;
    end
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
    import pipe3_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic [15:0]        imem_data,
    output logic               stall,
    output logic               retire_valid,
    output logic [3:0]         retire_dest,
    output logic [DATA_W-1:0]  retire_value
);
    localparam int OP_LSB = INSTR_W - OPC_W;
    localparam int RD_LSB = 2 * REG_W;
    localparam int RA_LSB = REG_W;

    logic [ADDR_W-1:0] pc_q;
    fetch_lat_t        fl_q;
    logic              ol_vld_q;
    logic [OPC_W-1:0]  ol_op_q;
    logic [REG_W-1:0]  ol_rd_q;
    logic [DATA_W-1:0] ol_a_q;
    logic [DATA_W-1:0] ol_b_q;

    logic [DATA_W-1:0] src_a;
    logic [DATA_W-1:0] src_b;
    logic [DATA_W-1:0] alu_y;
    fetch_lat_t        fetched;
    ctl_e              mode;

    always_comb begin
        fetched.vld = 1'b1;
        fetched.op  = imem_data[OP_LSB +: OPC_W];
        fetched.rd  = imem_data[RD_LSB +: REG_W];
        fetched.ra  = imem_data[RA_LSB +: REG_W];
        fetched.rb  = imem_data[0 +: REG_W];
    end

    pipe3_hazard u_hazard (
        .fl_vld (fl_q.vld),
        .fl_ra  (fl_q.ra),
        .fl_rb  (fl_q.rb),
        .op_vld (ol_vld_q),
        .op_rd  (ol_rd_q),
        .mode   (mode)
    );

    pipe3_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (fl_q.ra),
        .rd_b_addr (fl_q.rb),
        .rd_a_data (src_a),
        .rd_b_data (src_b),
        .wr_en     (ol_vld_q),
        .wr_addr   (ol_rd_q),
        .wr_data   (alu_y)
    );

    pipe3_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ol_op_q),
        .a  (ol_a_q),
        .b  (ol_b_q),
        .y  (alu_y)
    );

    // State register: pipeline latches and PC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            fl_q     <= '0;
            ol_vld_q <= 1'b0;
            ol_op_q  <= '0;
            ol_rd_q  <= '0;
            ol_a_q   <= '0;
            ol_b_q   <= '0;
        end else begin
            unique case (mode)
                CTL_RUN: begin
                    pc_q     <= pc_q + 1'b1;
                    fl_q     <= fetched;
                    ol_vld_q <= fl_q.vld;
                    ol_op_q  <= fl_q.op;
                    ol_rd_q  <= fl_q.rd;
                    ol_a_q   <= src_a;
                    ol_b_q   <= src_b;
                end
                CTL_HOLD: begin
                    ol_vld_q <= 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        imem_addr    = pc_q;
        stall        = (mode == CTL_HOLD);
        retire_valid = ol_vld_q;
        retire_dest  = ol_rd_q;
        retire_value = alu_y;
    end
endmodule

// File: rtl/pipe3_core_chk.sv
module pipe3_core_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc,
    input logic              stall,
    input logic              retire_vld
);
    // R1: PC is zero on the first cycle out of reset
    p_reset_pc_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pc == '0));

    // R4: PC steps by one in every RUN cycle
    p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    // R6: HOLD freezes the PC and yields a bubble
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pc) && !retire_vld));

    // R5: a stall never lasts two cycles
    p_stall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R5: a stall only occurs while a producer retires
    p_stall_producer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> retire_vld);
endmodule

bind pipe3_core pipe3_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc         (imem_addr),
    .stall      (stall),
    .retire_vld (retire_valid)
);

// File: tb/pipe3_core_test.sv
module pipe3_core_test;
    localparam int NPROG = 11;

    // R2 encoding: {op, rd, ra, rb}
    localparam logic [15:0] PROG [NPROG] = '{
        16'h0123, 16'h1456, 16'h2714, 16'h3879, 16'h4A8B, 16'h5CD0,
        16'h0DCC, 16'h10FE, 16'h6200, 16'h0321, 16'h0593
    };
    // Expected retirements {rd, value}, fetch order
    localparam logic [19:0] EXPV [NPROG] = '{
        {4'h1, 16'h0005}, {4'h4, 16'hFFFF}, {4'h7, 16'h0005},
        {4'h8, 16'h000D}, {4'hA, 16'h0006}, {4'hC, 16'h000D},
        {4'hD, 16'h001A}, {4'h0, 16'h0001}, {4'h2, 16'h0000},
        {4'h3, 16'h0005}, {4'h5, 16'h000E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [15:0] imem_data;
    logic        stall;
    logic        retire_valid;
    logic [3:0]  retire_dest;
    logic [15:0] retire_value;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    always_comb begin
        imem_data = 16'h6000;
        for (int i = 0; i < NPROG; i++) begin
            if (imem_addr == 8'(i)) imem_data = PROG[i];
        end
    end

    pipe3_core uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .imem_addr    (imem_addr),
        .imem_data    (imem_data),
        .stall        (stall),
        .retire_valid (retire_valid),
        .retire_dest  (retire_dest),
        .retire_value (retire_value)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] prev_pc;
        logic       prev_stall;
        int idx;
        int cyc;
        int stalls;
        int last_cyc;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == 0, "R1 pc in reset", imem_addr, 0);
        chk(!retire_valid && !stall, "R1 idle in reset", {retire_valid, stall}, 0);
        rst_n = 1'b1;

        prev_pc = 0; prev_stall = 0; idx = 0; cyc = 0; stalls = 0; last_cyc = 0;
        while (idx < NPROG && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) chk(!retire_valid, "R1 no retire after first edge", retire_valid, 0);
            if (prev_stall) begin
                chk(imem_addr == prev_pc, "R6 pc frozen", imem_addr, prev_pc);
                chk(!retire_valid, "R6 bubble", retire_valid, 0);
                chk(!stall, "R5 single-cycle stall", stall, 0);
            end else begin
                chk(imem_addr == 8'(prev_pc + 1), "R4 pc step", imem_addr, 8'(prev_pc + 1));
            end
            if (stall) begin
                stalls++;
                chk(retire_valid, "R5 stall with producer", retire_valid, 1);
            end
            if (retire_valid) begin
                // R3 R7 R8 R9: value and order of each retirement
                chk({retire_dest, retire_value} == EXPV[idx], "R7 retire sequence",
                    {retire_dest, retire_value}, EXPV[idx]);
                if (idx == 8) chk(retire_value == 0, "R9 undefined op", retire_value, 0);
                if (idx == 1) chk(retire_value == 16'hFFFF, "R3 sub wraps", retire_value, 16'hFFFF);
                idx++;
                last_cyc = cyc;
            end
            prev_pc = imem_addr;
            prev_stall = stall;
        end
        chk(stalls == 7, "R5 stall count", stalls, 7);
        chk(last_cyc == 19, "R7 last retire cycle", last_cyc, 19);

        // Mid-run reset, then register contents must be back to index values (R8)
        rst_n = 1'b0;
        @(negedge clk);
        chk(imem_addr == 0 && !retire_valid && !stall, "R1 reset mid-run",
            {imem_addr, retire_valid, stall}, 0);
        rst_n = 1'b1;
        idx = 0;
        cyc = 0;
        while (idx < 2 && cyc < 20) begin
            @(negedge clk);
            cyc++;
            if (retire_valid) begin
                chk({retire_dest, retire_value} == EXPV[idx], "R8 reset register values",
                    {retire_dest, retire_value}, EXPV[idx]);
                idx++;
            end
        end
        chk(idx == 2, "R8 retirements after reset", idx, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule